// File: doc/BRIEF.md
# Processor Status Register with Write Arbitration

This block holds the eight-bit processor status word: three arithmetic condition flags (zero, digit carry, carry), two reset-cause bits (a time-out bit and an idle bit that drops on a sleep), and the bank select bits used by the data-memory decoder. Software can name the word as the destination of any instruction, like any other file register. The ALU can refresh its flags in the same cycle. For every bit, the block decides whether the bus write, the ALU, the reset-cause logic or nothing sets it.

The CPU core drives the bus write port and the per-flag ALU update enables. The reset controller drives the four reset-cause strobes. The registered word is read out on `stat_o`. The bank bits use either an asynchronous or a synchronous reset, chosen by a parameter. Because of the masking rules, the value read back after a software write can differ from the value that was written.

Top module: `pstat_arb`

## Requirements
- R1: While `rst_ni` is low, the bank bits [7:5] read zero. The condition flags [2:0] keep their value through reset, and bus writes and ALU updates during reset do not change them.
- R2: A bus write with no ALU update enable asserted loads bits [7:5] and [2:0] from `wr_data_i` on the next clock edge.
- R3: An ALU update with no bus write loads each flag whose enable is set from `alu_flags_i` (bit 0 carry, bit 1 digit carry, bit 2 zero) and leaves the other flags unchanged.
- R4: When a bus write and an ALU update fall in the same cycle, each flag whose update enable is set takes the ALU value. The flags that are not enabled, and the bank bits, take the bus value.
- R5: Bus writes never change the time-out bit [4] or the idle bit [3].
- R6: `por_i` sets both bit [4] and bit [3] to 1.
- R7: `wdt_expire_i` clears bit [4] and leaves bit [3] unchanged.
- R8: `sleep_i` clears bit [3] and sets bit [4].
- R9: `wdt_clr_i` sets both bit [4] and bit [3].
- R10: When several reset-cause strobes are high together, only the one with the highest priority acts. The order, from highest to lowest, is power-on, watchdog expiry, sleep, watchdog clear.
- R11: In a cycle with no bus write, no ALU update and no strobe, the whole word holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| wr_en_i | input | 1 | Bus write to the status word |
| wr_data_i | input | DATA_W | Bus write data |
| alu_upd_i | input | 3 | Per-flag ALU update enables (carry, digit carry, zero) |
| alu_flags_i | input | 3 | ALU flag values, in the same bit order |
| por_i | input | 1 | Power-on strobe |
| wdt_expire_i | input | 1 | Watchdog time-out strobe |
| sleep_i | input | 1 | Sleep-entry strobe |
| wdt_clr_i | input | 1 | Watchdog-clear strobe |
| stat_o | output | DATA_W | Registered status word |

## Verification
Two collisions can happen in one cycle. The first is a bus write to the word together with an ALU flag update. The second is two or more reset-cause strobes together. Directed steps drive a write whose data disagrees with the ALU values on some flags, so that the read-back shows which source won for each bit. Stacked strobes are judged against the priority order. A free-running random phase then overlaps all sources on every clock and compares the word with a behavioural model.

// File: rtl/pstat_pkg.sv
package pstat_pkg;

   // condition flags occupy the low bits of the word
   localparam int unsigned FLAG_N     = 3;
   localparam int unsigned FLAG_CARRY = 0;
   localparam int unsigned FLAG_HALF  = 1;
   localparam int unsigned FLAG_ZERO  = 2;

   // reset-cause pair sits directly above the flags
   localparam int unsigned CAUSE_IDLE_BIT = FLAG_N;
   localparam int unsigned CAUSE_TMO_BIT  = FLAG_N + 1;
   localparam int unsigned BANK_LSB       = FLAG_N + 2;

   typedef struct packed {
      logic por;
      logic expire;
      logic sleep;
      logic clr;
   } cause_ev_t;

   typedef enum logic [2:0] {
      CA_HOLD,
      CA_POR,
      CA_EXPIRE,
      CA_SLEEP,
      CA_CLR
   } cause_act_e;

endpackage

// File: rtl/pstat_flag_cell.sv
// One condition flag: the ALU update outranks the bus write, reset freezes it.
module pstat_flag_cell (
   input  logic clk_i,
   input  logic run_i,
   input  logic upd_i,
   input  logic alu_i,
   input  logic wr_i,
   input  logic bus_i,
   output logic q_o
);
   logic nxt;

   always_comb begin
      nxt = q_o;
      if (run_i) begin
         if (upd_i)
            nxt = alu_i;
         else if (wr_i)
            nxt = bus_i;
      end
   end

   always_ff @(posedge clk_i) begin
      q_o <= nxt;
   end
endmodule

// File: rtl/pstat_cause.sv
// Reset-cause pair; software has no path into it.
module pstat_cause
   import pstat_pkg::*;
(
   input  logic      clk_i,
   input  cause_ev_t ev_i,
   output logic      tmo_o,
   output logic      idle_o
);
   cause_act_e act;
   logic       tmo_nxt;
   logic       idle_nxt;

   always_comb begin
      if (ev_i.por)         act = CA_POR;
      else if (ev_i.expire) act = CA_EXPIRE;
      else if (ev_i.sleep)  act = CA_SLEEP;
      else if (ev_i.clr)    act = CA_CLR;
      else                  act = CA_HOLD;
   end

   always_comb begin
      tmo_nxt  = tmo_o;
      idle_nxt = idle_o;
      unique case (act)
         CA_POR:    begin tmo_nxt = 1'b1; idle_nxt = 1'b1; end
         CA_EXPIRE: begin tmo_nxt = 1'b0; end
         CA_SLEEP:  begin tmo_nxt = 1'b1; idle_nxt = 1'b0; end
         CA_CLR:    begin tmo_nxt = 1'b1; idle_nxt = 1'b1; end
         default:   begin end
      endcase
   end

   always_ff @(posedge clk_i) begin
      tmo_o  <= tmo_nxt;
      idle_o <= idle_nxt;
   end
endmodule

// File: rtl/pstat_bank.sv
// Bank select field; the reset style is picked by a parameter.
module pstat_bank #(
   parameter int unsigned W         = 2,
   parameter bit          ASYNC_RST = 1'b1
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         we_i,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   generate
      if (W < 1) begin : g_bad_w
         $error("pstat_bank: W must be at least 1");
      end

      if (ASYNC_RST) begin : g_async
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)   q_o <= '0;
            else if (we_i) q_o <= d_i;
         end
      end else begin : g_sync
         always_ff @(posedge clk_i) begin
            if (!rst_ni)   q_o <= '0;
            else if (we_i) q_o <= d_i;
         end
      end
   endgenerate
endmodule

// File: rtl/pstat_arb.sv
module pstat_arb
   import pstat_pkg::*;
#(
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned DIR_BANK_W = 2,
   parameter int unsigned IND_BANK_W = 1,
   parameter bit          ASYNC_RST  = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_en_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic [FLAG_N-1:0] alu_upd_i,
   input  logic [FLAG_N-1:0] alu_flags_i,
   input  logic              por_i,
   input  logic              wdt_expire_i,
   input  logic              sleep_i,
   input  logic              wdt_clr_i,
   output logic [DATA_W-1:0] stat_o
);
   localparam int unsigned DIR_LSB = BANK_LSB;
   localparam int unsigned IND_LSB = DIR_LSB + DIR_BANK_W;
   localparam int unsigned REG_W   = IND_LSB + IND_BANK_W;

   generate
      if (REG_W != DATA_W) begin : g_bad_width
         $error("pstat_arb: field widths do not add up to DATA_W");
      end
      if (DIR_BANK_W < 1 || IND_BANK_W < 1) begin : g_bad_bank
         $error("pstat_arb: each bank field needs at least one bit");
      end
   endgenerate

   logic [FLAG_N-1:0]     flag_q;
   logic [DIR_BANK_W-1:0] dir_q;
   logic [IND_BANK_W-1:0] ind_q;
   logic                  tmo_q;
   logic                  idle_q;
   cause_ev_t             ev;

   // bus data on the cause bits goes nowhere by design
   logic unused_cause_wr;
   assign unused_cause_wr = ^wr_data_i[CAUSE_TMO_BIT:CAUSE_IDLE_BIT];

   generate
      for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
         pstat_flag_cell u_flag (
            .clk_i (clk_i),
            .run_i (rst_ni),
            .upd_i (alu_upd_i[i]),
            .alu_i (alu_flags_i[i]),
            .wr_i  (wr_en_i),
            .bus_i (wr_data_i[i]),
            .q_o   (flag_q[i])
         );
      end
   endgenerate

   always_comb begin
      ev.por    = por_i;
      ev.expire = wdt_expire_i;
      ev.sleep  = sleep_i;
      ev.clr    = wdt_clr_i;
   end

   pstat_cause u_cause (
      .clk_i  (clk_i),
      .ev_i   (ev),
      .tmo_o  (tmo_q),
      .idle_o (idle_q)
   );

   pstat_bank #(.W(DIR_BANK_W), .ASYNC_RST(ASYNC_RST)) u_dir (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (wr_en_i),
      .d_i    (wr_data_i[DIR_LSB +: DIR_BANK_W]),
      .q_o    (dir_q)
   );

   pstat_bank #(.W(IND_BANK_W), .ASYNC_RST(ASYNC_RST)) u_ind (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (wr_en_i),
      .d_i    (wr_data_i[IND_LSB +: IND_BANK_W]),
      .q_o    (ind_q)
   );

   always_comb begin
      stat_o                           = '0;
      stat_o[FLAG_N-1:0]               = flag_q;
      stat_o[CAUSE_IDLE_BIT]           = idle_q;
      stat_o[CAUSE_TMO_BIT]            = tmo_q;
      stat_o[DIR_LSB +: DIR_BANK_W]    = dir_q;
      stat_o[IND_LSB +: IND_BANK_W]    = ind_q;
   end
endmodule

// File: rtl/pstat_chk.sv
module pstat_chk
   import pstat_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              wr_en_i,
   input logic [DATA_W-1:0] wr_data_i,
   input logic [FLAG_N-1:0] alu_upd_i,
   input logic [FLAG_N-1:0] alu_flags_i,
   input logic              por_i,
   input logic              wdt_expire_i,
   input logic              sleep_i,
   input logic              wdt_clr_i,
   input logic [DATA_W-1:0] stat_o
);
   localparam int unsigned T = CAUSE_TMO_BIT;
   localparam int unsigned I = CAUSE_IDLE_BIT;

   logic any_ev;
   assign any_ev = por_i | wdt_expire_i | sleep_i | wdt_clr_i;

   assert_bus_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && alu_upd_i == '0) |=>
         (stat_o[DATA_W-1:BANK_LSB] == $past(wr_data_i[DATA_W-1:BANK_LSB]) &&
          stat_o[FLAG_N-1:0] == $past(wr_data_i[FLAG_N-1:0])));

   assert_alu_wins_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (alu_upd_i != '0) |=>
         ((stat_o[FLAG_N-1:0] & $past(alu_upd_i)) == ($past(alu_flags_i) & $past(alu_upd_i))));

   assert_cause_no_bus_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && !any_ev) |=> $stable(stat_o[T:I]));

   assert_por_sets_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      por_i |=> (stat_o[T] && stat_o[I]));

   assert_expire_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wdt_expire_i && !por_i) |=> (!stat_o[T] && $stable(stat_o[I])));

   assert_sleep_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sleep_i && !por_i && !wdt_expire_i) |=> (stat_o[T] && !stat_o[I]));

   assert_clr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wdt_clr_i && !por_i && !wdt_expire_i && !sleep_i) |=> (stat_o[T] && stat_o[I]));

   assert_idle_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!wr_en_i && alu_upd_i == '0 && !any_ev) |=> $stable(stat_o));
endmodule

bind pstat_arb pstat_chk #(.DATA_W(DATA_W)) u_chk (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .wr_en_i      (wr_en_i),
   .wr_data_i    (wr_data_i),
   .alu_upd_i    (alu_upd_i),
   .alu_flags_i  (alu_flags_i),
   .por_i        (por_i),
   .wdt_expire_i (wdt_expire_i),
   .sleep_i      (sleep_i),
   .wdt_clr_i    (wdt_clr_i),
   .stat_o       (stat_o)
);

// File: tb/sim_pstat_arb.sv
module sim_pstat_arb;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr = 1'b0;
   logic [7:0] wd = '0;
   logic [2:0] upd = '0;
   logic [2:0] alu = '0;
   logic       por = 1'b0, expire = 1'b0, slp = 1'b0, clr = 1'b0;
   logic [7:0] stat;

   int    n_run = 0;
   int    n_fail = 0;
   string cur_req = "R1";
   bit    done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pstat_arb u0 (
      .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr), .wr_data_i(wd),
      .alu_upd_i(upd), .alu_flags_i(alu), .por_i(por),
      .wdt_expire_i(expire), .sleep_i(slp), .wdt_clr_i(clr), .stat_o(stat)
   );

   // behavioural reference: separate pieces, validity tracked per bit
   logic [2:0] m_bank = '0;
   logic [2:0] m_flag = '0;
   logic [2:0] m_fknown = '0;
   logic       m_tmo = 1'b0, m_idle = 1'b0;
   bit         m_cknown = 1'b0;
   bit         m_bknown = 1'b0;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_bank   = '0;
         m_bknown = 1'b1;
      end else if (wr) begin
         m_bank   = wd[7:5];
         m_bknown = 1'b1;
      end
   end

   always @(posedge clk) begin
      if (rst_n) begin
         for (int i = 0; i < 3; i++) begin
            if (upd[i]) begin
               m_flag[i] = alu[i]; m_fknown[i] = 1'b1;
            end else if (wr) begin
               m_flag[i] = wd[i]; m_fknown[i] = 1'b1;
            end
         end
      end
      if (por) begin
         m_tmo = 1'b1; m_idle = 1'b1; m_cknown = 1'b1;
      end else if (expire) begin
         m_tmo = 1'b0;
      end else if (slp) begin
         m_tmo = 1'b1; m_idle = 1'b0;
      end else if (clr) begin
         m_tmo = 1'b1; m_idle = 1'b1;
      end
   end

   always @(negedge clk) begin
      logic [7:0] ev, mk;
      if (!done) begin
         ev = {m_bank, m_tmo, m_idle, m_flag};
         mk = {{3{m_bknown}}, m_cknown, m_cknown, m_fknown};
         n_run++;
         if (((stat ^ ev) & mk) != 8'h00) begin
            n_fail++;
            $display("FAIL %s model compare: got %02h expected %02h (mask %02h)",
                     cur_req, stat, ev, mk);
         end
      end
   end

   task automatic chk(input string req, input logic [7:0] mask, input logic [7:0] exp);
      n_run++;
      if ((stat & mask) !== (exp & mask)) begin
         n_fail++;
         $display("FAIL %s directed: got %02h expected %02h", req, stat & mask, exp & mask);
      end
   endtask

   task automatic idle_in();
      wr = 0; wd = '0; upd = '0; alu = '0;
      por = 0; expire = 0; slp = 0; clr = 0;
   endtask

   // drive one cycle of stimulus, then an idle cycle, then check the word
   task automatic cyc(input string req, input bit w, input logic [7:0] d,
                      input logic [2:0] u, input logic [2:0] a,
                      input bit p, input bit ex, input bit sl, input bit cl,
                      input logic [7:0] exp);
      @(posedge clk); #1;
      cur_req = req;
      wr = w; wd = d; upd = u; alu = a;
      por = p; expire = ex; slp = sl; clr = cl;
      @(posedge clk); #1;
      idle_in();
      #2;
      chk(req, 8'hFF, exp);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: run did not finish, got timeout expected completion");
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin : stim
      // R1 R6: reset with a power-on strobe inside it
      cur_req = "R6";
      repeat (2) @(posedge clk);
      #1 por = 1;
      @(posedge clk); #1 por = 0;
      @(posedge clk); #3;
      chk("R1", 8'hF8, 8'h18);
      #1 rst_n = 1;

      cyc("R2",  1, 8'hFF, 3'b000, 3'b000, 0,0,0,0, 8'hFF);
      cyc("R5",  1, 8'h00, 3'b000, 3'b000, 0,0,0,0, 8'h18);
      cyc("R3",  0, 8'hFF, 3'b101, 3'b101, 0,0,0,0, 8'h1D);
      cyc("R4",  1, 8'hE2, 3'b001, 3'b000, 0,0,0,0, 8'hFA);
      cyc("R4",  1, 8'h07, 3'b111, 3'b000, 0,0,0,0, 8'h18);
      cyc("R7",  0, 8'h00, 3'b000, 3'b000, 0,1,0,0, 8'h08);
      cyc("R9",  0, 8'h00, 3'b000, 3'b000, 0,0,0,1, 8'h18);
      cyc("R8",  0, 8'h00, 3'b000, 3'b000, 0,0,1,0, 8'h10);
      cyc("R10", 0, 8'h00, 3'b000, 3'b000, 0,1,1,0, 8'h00);
      cyc("R10", 0, 8'h00, 3'b000, 3'b000, 1,1,0,0, 8'h18);
      cyc("R10", 0, 8'h00, 3'b000, 3'b000, 0,0,1,1, 8'h10);
      cyc("R11", 0, 8'h00, 3'b000, 3'b000, 0,0,0,0, 8'h10);
      cyc("R5",  1, 8'h18, 3'b000, 3'b000, 0,0,0,0, 8'h00 | 8'h10);
      cyc("R4",  1, 8'h60, 3'b111, 3'b111, 0,0,0,0, 8'h77);

      // R1: reset clears the bank bits, flags survive despite a write and update
      @(posedge clk); #1;
      cur_req = "R1";
      rst_n = 0; wr = 1; wd = 8'h00; upd = 3'b111; alu = 3'b000;
      #2 chk("R1", 8'hE7, 8'h07);
      repeat (2) @(posedge clk);
      #1 idle_in();
      #2 chk("R1", 8'hFF, 8'h17);
      rst_n = 1;

      // mixed overlap of every source
      cur_req = "R10";
      for (int k = 0; k < 600; k++) begin
         @(posedge clk); #1;
         wr = $urandom_range(0, 1);
         wd = 8'($urandom);
         upd = 3'($urandom);
         alu = 3'($urandom);
         por = ($urandom_range(0, 15) == 0);
         expire = ($urandom_range(0, 5) == 0);
         slp = ($urandom_range(0, 4) == 0);
         clr = ($urandom_range(0, 3) == 0);
      end
      @(posedge clk); #1 idle_in();
      @(posedge clk); #1;

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule